// File: doc/BRIEF.md
# Baud Tick Generator with Prescaler Select

This block produces the 16x oversampling tick for a 16550-style serial port. It runs from a fixed 7.3728 MHz reference clock, in the same clock domain as the port logic, and emits a one-cycle enable pulse called the baud tick. The serial shifters use this pulse. Software sets the rate through a 16-bit divisor, written one byte at a time through a low-byte strobe and a high-byte strobe that share one data bus.

Only the lower fifteen bits of the divisor set the divide count. The top bit chooses the prescaler that feeds the counter. When it is clear, the reference is divided by four. When it is set, the reference is used directly, but only while the per-port high-speed enable input is asserted. With high-speed disabled, the divide-by-four path is always used. As a result, 0x0001 and 0x8001 both give 115200 bps. With high-speed enabled, 0x8001 to 0x8004 give 460800, 230400, 153600 and 115200 bps. Every divisor write and every change of the high-speed enable restarts the count. The new rate then applies from the next tick.

Top module: `baudgen_top`

## Requirements
- R1: While reset is asserted the tick is low. Reset leaves the divisor at 0x0001 and the high-speed path off, so the first tick after release comes 4 clocks after the reset is released.
- R2: With the prescaler in divide-by-4 mode, ticks are spaced 4*N clocks apart, where N is divisor bits [14:0].
- R3: Divisor bit 15 has no effect while the high-speed enable is low. 0x8001 gives the same 4-clock spacing as 0x0001.
- R4: With high-speed enabled and bit 15 set, ticks are spaced N clocks apart. 0x8001, 0x8002, 0x8003 and 0x8004 give 1, 2, 3 and 4 clocks.
- R5: With high-speed enabled and bit 15 clear, the divide-by-4 path is still used (0x0003 gives 12 clocks).
- R6: A 15-bit divisor field of zero acts as 1 in both modes.
- R7: The largest divide count is 32767. With high-speed enabled, 0xFFFF gives 32767 clocks.
- R8: A write to either divisor byte restarts the generator. The tick is low in the cycle after the write, and the next tick comes exactly one new period after the write edge. A write to only one byte keeps the other byte.
- R9: A change of the high-speed enable alone restarts the generator in the same way as a write, and the spacing follows the new mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 7.3728 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_lo_we | input | 1 | Write strobe for divisor bits [7:0] |
| div_hi_we | input | 1 | Write strobe for divisor bits [15:8] |
| wr_data | input | 8 | Byte written by either strobe |
| hs_en | input | 1 | Per-port high-speed enable |
| baud_tick | output | 1 | 16x oversampling tick, one clock wide except at a spacing of 1 |

## Verification
A wrong prescaler phase or a stale count shows up at once as a wrong spacing for the first tick after a restart. This spacing is measured from the write edge or the enable-change edge, so an error appears within one programmed period. A prescaler select that ignores the enable, or that uses bit 15 as part of the count, changes the spacing by a factor of four or by 32768. This is visible on the first interval. A tick that leaks during a restart shows up as an interval shorter than expected, or as a pulse in the cycle after the strobe.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;
   typedef enum logic {
      PATH_QUARTER = 1'b0,
      PATH_DIRECT  = 1'b1
   } ref_path_e;

   function automatic int unsigned lane_count(input int unsigned div_w, input int unsigned byte_w);
      return div_w / byte_w;
   endfunction
endpackage

// File: rtl/baudgen_divreg.sv
module baudgen_divreg #(
   parameter int unsigned DIV_W = 16,
   parameter int unsigned BYTE_W = 8,
   parameter logic [DIV_W-1:0] RESET_DIV = 16'h0001,
   localparam int unsigned LANES = baudgen_pkg::lane_count(DIV_W, BYTE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LANES-1:0]  lane_we,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [DIV_W-1:0]  div_q,
   output logic              wr_any
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            div_q[g*BYTE_W +: BYTE_W] <= RESET_DIV[g*BYTE_W +: BYTE_W];
         else if (lane_we[g])
            div_q[g*BYTE_W +: BYTE_W] <= wr_data;
      end
   end

   assign wr_any = |lane_we;
endmodule

// File: rtl/baudgen_prescale.sv
module baudgen_prescale #(
   parameter int unsigned PRESCALE = 4,
   localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic bypass,
   output logic step
);
   if (PRESCALE > 1) begin : g_div
      logic [PW-1:0] pcnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pcnt <= '0;
         else if (clear || pcnt == PW'(PRESCALE - 1))
            pcnt <= '0;
         else
            pcnt <= pcnt + 1'b1;
      end
      assign step = bypass || (pcnt == PW'(PRESCALE - 1));
   end else begin : g_pass
      logic unused_in;
      assign unused_in = clk ^ rst_n ^ clear ^ bypass;
      assign step = 1'b1;
   end
endmodule

// File: rtl/baudgen_counter.sv
module baudgen_counter #(
   parameter int unsigned CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  logic [CNT_W-1:0] limit_m1,
   output logic             tick
);
   logic [CNT_W-1:0] cnt;
   logic             wrap;

   assign wrap = (cnt >= limit_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (clear) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else begin
         tick <= step && wrap;
         if (step)
            cnt <= wrap ? '0 : cnt + 1'b1;
      end
   end
endmodule

// File: rtl/baudgen_top.sv
module baudgen_top #(
   parameter int unsigned DIV_W = 16,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned PRESCALE = 4,
   parameter logic [DIV_W-1:0] RESET_DIV = 16'h0001,
   localparam int unsigned CNT_W = DIV_W - 1,
   localparam int unsigned LANES = baudgen_pkg::lane_count(DIV_W, BYTE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              div_lo_we,
   input  logic              div_hi_we,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              hs_en,
   output logic              baud_tick
);
   if (LANES != 2 || DIV_W != LANES * BYTE_W) begin : g_bad_width
      $error("baudgen_top: divisor must be exactly two byte lanes");
   end
   if (PRESCALE < 1) begin : g_bad_pre
      $error("baudgen_top: PRESCALE must be at least 1");
   end

   logic [DIV_W-1:0] div_q;
   logic             wr_any;
   logic             hs_q;
   logic             reload;
   logic             step;
   logic [CNT_W-1:0] field;
   logic [CNT_W-1:0] limit_m1;
   baudgen_pkg::ref_path_e path;
   logic             fast_sel;

   baudgen_divreg #(
      .DIV_W(DIV_W), .BYTE_W(BYTE_W), .RESET_DIV(RESET_DIV)
   ) u_divreg (
      .clk(clk), .rst_n(rst_n),
      .lane_we({div_hi_we, div_lo_we}),
      .wr_data(wr_data),
      .div_q(div_q), .wr_any(wr_any)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hs_q <= 1'b0;
      else        hs_q <= hs_en;
   end

   assign reload   = wr_any || (hs_en != hs_q);
   assign path     = (hs_q && div_q[DIV_W-1]) ? baudgen_pkg::PATH_DIRECT
                                               : baudgen_pkg::PATH_QUARTER;
   assign fast_sel = (path == baudgen_pkg::PATH_DIRECT);
   assign field    = div_q[CNT_W-1:0];
   assign limit_m1 = (field == '0) ? '0 : field - 1'b1;

   baudgen_prescale #(.PRESCALE(PRESCALE)) u_pre (
      .clk(clk), .rst_n(rst_n), .clear(reload),
      .bypass(fast_sel), .step(step)
   );

   baudgen_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clear(reload),
      .step(step), .limit_m1(limit_m1), .tick(baud_tick)
   );
endmodule

// File: rtl/baudgen_chk.sv
module baudgen_chk (
   input logic clk,
   input logic rst_n,
   input logic div_lo_we,
   input logic div_hi_we,
   input logic hs_en,
   input logic baud_tick,
   input logic fast_sel
);
   logic hs_prev;
   logic hs_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_prev  <= 1'b0;
         hs_valid <= 1'b0;
      end else begin
         hs_prev  <= hs_en;
         hs_valid <= 1'b1;
      end
   end

   always @(negedge clk)
      if (!rst_n) AST_RST_QUIET: assert (!baud_tick); // R1

   AST_WRITE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (div_lo_we || div_hi_we) |=> !baud_tick); // R8

   AST_HS_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_valid && hs_en != hs_prev) |=> !baud_tick); // R9

   AST_BIT15_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!hs_en && baud_tick) |=> !baud_tick); // R3

   AST_QUARTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!fast_sel && baud_tick) |=> !baud_tick); // R5
endmodule

bind baudgen_top baudgen_chk chk_i (
   .clk(clk), .rst_n(rst_n), .div_lo_we(div_lo_we), .div_hi_we(div_hi_we),
   .hs_en(hs_en), .baud_tick(baud_tick), .fast_sel(fast_sel)
);

// File: tb/baudgen_top_tb_top.sv
module baudgen_top_tb_top;
   localparam time CLK_PERIOD = 136ns;
   localparam int  WATCHDOG_CYC = 190000;

   typedef struct { int exp; string req; } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       div_lo_we = 1'b0;
   logic       div_hi_we = 1'b0;
   logic [7:0] wr_data = '0;
   logic       hs_en = 1'b0;
   logic       baud_tick;

   int   cyc = 0;
   int   last_ref = 0;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   logic [15:0] shadow = 16'h0001;
   item_t exp_q[$];

   baudgen_top dut_i (
      .clk(clk), .rst_n(rst_n), .div_lo_we(div_lo_we), .div_hi_we(div_hi_we),
      .wr_data(wr_data), .hs_en(hs_en), .baud_tick(baud_tick)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic int spacing(input logic [15:0] d, input logic hs);
      int f;
      f = (d[14:0] == 15'd0) ? 1 : int'(d[14:0]);
      return (hs && d[15]) ? f : 4 * f;
   endfunction

   // monitor: compare each tick interval with the next expected item
   always @(negedge clk) begin
      if (rst_n && baud_tick && exp_q.size() != 0) begin
         item_t it;
         int gap;
         it  = exp_q.pop_front();
         gap = cyc - last_ref;
         last_ref = cyc;
         n_chk++;
         if (gap != it.exp) begin
            n_fail++;
            $display("FAIL %s: tick interval actual %0d expected %0d", it.req, gap, it.exp);
         end
      end else if (rst_n && baud_tick) begin
         last_ref = cyc;
      end
   end

   task automatic strobe(input bit lo, input bit hi, input logic [7:0] d, input logic hs);
      @(negedge clk);
      div_lo_we = lo;
      div_hi_we = hi;
      wr_data   = d;
      hs_en     = hs;
      @(posedge clk);
      #1 last_ref = cyc;
      if (lo) shadow[7:0]  = d;
      if (hi) shadow[15:8] = d;
      @(negedge clk);
      div_lo_we = 1'b0;
      div_hi_we = 1'b0;
   endtask

   task automatic run_case(input bit lo, input bit hi, input logic [15:0] d,
                           input logic hs, input int n, input string req);
      wait (exp_q.size() == 0);
      if (lo) strobe(1'b1, 1'b0, d[7:0], hs);
      if (hi) strobe(1'b0, 1'b1, d[15:8], hs);
      if (!lo && !hi) strobe(1'b0, 1'b0, 8'h00, hs);
      for (int k = 0; k < n; k++) begin
         item_t it;
         it.exp = spacing(shadow, hs);
         it.req = req;
         exp_q.push_back(it);
      end
      wait (exp_q.size() == 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      n_chk++;
      if (baud_tick !== 1'b0) begin
         n_fail++;
         $display("FAIL R1: tick in reset actual %b expected 0", baud_tick);
      end
      begin
         item_t it;
         it.exp = 4; it.req = "R1";
         exp_q.push_back(it);
      end
      rst_n = 1'b1;
      last_ref = cyc;
      wait (exp_q.size() == 0);

      run_case(1, 1, 16'h0001, 1'b0, 3, "R2");
      run_case(1, 1, 16'h0005, 1'b0, 2, "R2");
      run_case(1, 1, 16'h8001, 1'b0, 3, "R3");
      run_case(1, 1, 16'h8001, 1'b1, 4, "R4");
      run_case(1, 1, 16'h8002, 1'b1, 3, "R4");
      run_case(1, 1, 16'h8003, 1'b1, 3, "R4");
      run_case(1, 1, 16'h8004, 1'b1, 3, "R4");
      run_case(1, 1, 16'h0003, 1'b1, 2, "R5");
      run_case(1, 1, 16'h0000, 1'b0, 2, "R6");
      run_case(1, 1, 16'h8000, 1'b1, 3, "R6");
      run_case(1, 1, 16'h00C8, 1'b0, 2, "R2");
      run_case(1, 1, 16'hFFFF, 1'b1, 2, "R7");
      run_case(1, 1, 16'h8002, 1'b0, 2, "R9");
      run_case(0, 0, 16'h0000, 1'b1, 3, "R9");
      run_case(1, 0, 16'h0005, 1'b1, 3, "R8");
      run_case(0, 1, 16'h0100, 1'b1, 2, "R8");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (WATCHDOG_CYC) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule